// File: doc/BRIEF.md
# Local Fault Ordered-Set Inserter

This block sits in a four-lane transmit path in which every beat is one column: one 8-bit character and one control flag per lane, with lane 0 in the low bits of the data bus. Each accepted column is cleaned and then either forwarded or overwritten. A lane whose code-violation flag is raised has its character replaced by the error control character. If fault propagation is enabled and any fault source is active, the whole column is replaced by the local-fault sequence ordered set instead. The fault sources are per-lane signal loss, per-lane byte-sync loss and channel alignment loss.

Columns travel on a valid/ready stream. The result is held in one output register, so a column appears one cycle after it is accepted. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output column stays frozen and no input is taken. The fault and enable pins are sampled together with the column they accompany. Every column is therefore handled whole, and the block never emits a partial ordered set. The lane count is fixed at four by the ordered set it emits.

Top module: `lf_column_inserter`

## Requirements
- R1: A column accepted on a rising edge appears on `out_data`/`out_ctl` with `out_valid` high after that same edge (one register of latency).
- R2: With no active fault, or with propagation disabled, and no violation flags, every lane's character and control flag reach the same output lane unchanged.
- R3: With `prop_en` high and any bit of `los` or `bsync_lost` high, or `align_lost` high, the output column is the local-fault set: lane 0 = 0x9C with control 1, lanes 1 and 2 = 0x00 with control 0, lane 3 = 0x01 with control 0.
- R4: With `prop_en` low, the fault sources have no effect on the output.
- R5: A lane whose `in_viol` bit is set leaves as 0xFE with control 1; the other lanes are unaffected.
- R6: When a fault replacement and code violations fall on the same column, the local-fault column wins on every lane.
- R7: Sequence ordered sets received on the input (local fault 0x9C/0x00/0x00/0x01 or remote fault 0x9C/0x00/0x00/0x02, control only on lane 0) pass through unchanged when no fault is being inserted.
- R8: While `out_valid` is high and `out_ready` is low, the output column is held stable and `in_ready` is low.
- R9: After reset, `out_valid` is low and the output data and control flags are all zero.
- R10: The fault decision is taken per column, so the first column accepted after the faults clear is forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input column valid |
| in_ready | output | 1 | Block can take a column |
| in_data | input | 32 | Lane characters, lane n in bits 8n+7:8n |
| in_ctl | input | 4 | Per-lane control flag |
| in_viol | input | 4 | Per-lane code-violation flag |
| los | input | 4 | Per-lane signal loss |
| bsync_lost | input | 4 | Per-lane byte-sync loss |
| align_lost | input | 1 | Lane alignment loss |
| prop_en | input | 1 | Fault propagation enable |
| out_valid | output | 1 | Output column valid |
| out_ready | input | 1 | Downstream can take a column |
| out_data | output | 32 | Output lane characters |
| out_ctl | output | 4 | Output control flags |

## Verification
Code-violation scrubbing and fault-column insertion can both act on the same column. To provoke this, the bench drives violation flags on every lane while a fault source is active and propagation is on, and it expects the exact local-fault column, with no 0xFE surviving anywhere (R6). The converse case is also driven: a fault source active with propagation off, together with a violation. There the scrub alone must show, on its own lane only. A stalled output with a new column waiting at the input is checked for a frozen output and for correct delivery once the stall is released.

// File: rtl/lfi_pkg.sv
package lfi_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] K28_4  = 8'h9C;
  localparam logic [CHAR_W-1:0] K30_7  = 8'hFE;
  localparam logic [CHAR_W-1:0] D0_0   = 8'h00;
  localparam logic [CHAR_W-1:0] D1_0   = 8'h01;

  // character of the local-fault ordered set for a given lane
  function automatic logic [CHAR_W-1:0] lf_code(input int lane);
    case (lane)
      0:       lf_code = K28_4;
      3:       lf_code = D1_0;
      default: lf_code = D0_0;
    endcase
  endfunction

  function automatic logic lf_ctl(input int lane);
    lf_ctl = (lane == 0);
  endfunction
endpackage

// File: rtl/lfi_fault_gate.sv
module lfi_fault_gate #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] los,
  input  logic [LANES-1:0] bsync_lost,
  input  logic             align_lost,
  input  logic             prop_en,
  output logic             fault
);
  logic any_lane;
  always_comb begin
    any_lane = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      any_lane = any_lane | los[i] | bsync_lost[i];
    end
    fault = prop_en & (any_lane | align_lost);
  end
endmodule

// File: rtl/lfi_lane_scrub.sv
module lfi_lane_scrub
  import lfi_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * CHAR_W
) (
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_ctl,
  input  logic [LANES-1:0] in_viol,
  output logic [DW-1:0]    out_data,
  output logic [LANES-1:0] out_ctl
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (in_viol[g]) begin
        out_data[g*CHAR_W +: CHAR_W] = K30_7;
        out_ctl[g]                   = 1'b1;
      end else begin
        out_data[g*CHAR_W +: CHAR_W] = in_data[g*CHAR_W +: CHAR_W];
        out_ctl[g]                   = in_ctl[g];
      end
    end
  end
endmodule

// File: rtl/lfi_column_select.sv
module lfi_column_select
  import lfi_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * CHAR_W
) (
  input  logic             fault,
  input  logic [DW-1:0]    pass_data,
  input  logic [LANES-1:0] pass_ctl,
  output logic [DW-1:0]    sel_data,
  output logic [LANES-1:0] sel_ctl
);
  logic [DW-1:0]    lf_data;
  logic [LANES-1:0] lf_ctl_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lf
    assign lf_data[g*CHAR_W +: CHAR_W] = lf_code(g);
    assign lf_ctl_v[g]                 = lf_ctl(g);
  end

  always_comb begin
    sel_data = fault ? lf_data  : pass_data;
    sel_ctl  = fault ? lf_ctl_v : pass_ctl;
  end
endmodule

// File: rtl/lf_column_inserter.sv
module lf_column_inserter
  import lfi_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_ctl,
  input  logic [LANES-1:0] in_viol,
  input  logic [LANES-1:0] los,
  input  logic [LANES-1:0] bsync_lost,
  input  logic             align_lost,
  input  logic             prop_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [LANES-1:0] out_ctl
);
  logic             fault;
  logic [DW-1:0]    scrub_data, next_data;
  logic [LANES-1:0] scrub_ctl, next_ctl;
  logic             take;

  lfi_fault_gate #(.LANES(LANES)) u_gate (
    .los(los), .bsync_lost(bsync_lost), .align_lost(align_lost),
    .prop_en(prop_en), .fault(fault)
  );

  lfi_lane_scrub #(.LANES(LANES)) u_scrub (
    .in_data(in_data), .in_ctl(in_ctl), .in_viol(in_viol),
    .out_data(scrub_data), .out_ctl(scrub_ctl)
  );

  lfi_column_select #(.LANES(LANES)) u_sel (
    .fault(fault), .pass_data(scrub_data), .pass_ctl(scrub_ctl),
    .sel_data(next_data), .sel_ctl(next_ctl)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctl   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= next_data;
        out_ctl   <= next_ctl;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lfi_chk.sv
module lfi_chk #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    in_data,
  input logic [LANES-1:0] in_ctl,
  input logic [LANES-1:0] in_viol,
  input logic             align_lost,
  input logic             prop_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [LANES-1:0] out_ctl
);
  // R1
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctl));

  // R3
  lf_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && prop_en && align_lost |=>
      out_data == 32'h0100009C && out_ctl == 4'b0001);

  // R4
  no_prop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !prop_en && in_viol == '0 |=>
      out_data == $past(in_data) && out_ctl == $past(in_ctl));

  // R5
  viol_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !prop_en && in_viol[0] |=>
      out_data[7:0] == 8'hFE && out_ctl[0]);
endmodule

bind lf_column_inserter lfi_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_ctl(in_ctl), .in_viol(in_viol),
  .align_lost(align_lost), .prop_en(prop_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_ctl(out_ctl)
);

// File: tb/lf_column_inserter_tb.sv
module lf_column_inserter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ctl = '0, in_viol = '0, los = '0, bsync_lost = '0;
  logic        align_lost = 1'b0, prop_en = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_ctl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lf_column_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctl(in_ctl), .in_viol(in_viol), .los(los),
    .bsync_lost(bsync_lost), .align_lost(align_lost), .prop_en(prop_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ctl(out_ctl)
  );

  localparam logic [31:0] LF = 32'h0100009C;

  // {req, prop, align, bsync, los, viol, ctl, data, exp_ctl, exp_data}
  localparam int NV = 13;
  localparam logic [89:0] VEC [NV] = '{
    {4'd2,  1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h44332211, 4'h0, 32'h44332211}, // R2
    {4'd2,  1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h5, 32'hA1B2C3D4, 4'h5, 32'hA1B2C3D4}, // R2
    {4'd3,  1'b1, 1'b0, 4'h0, 4'h4, 4'h0, 4'h0, 32'h12345678, 4'h1, LF},          // R3 los
    {4'd3,  1'b1, 1'b0, 4'h1, 4'h0, 4'h0, 4'h0, 32'h12345678, 4'h1, LF},          // R3 bsync
    {4'd3,  1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 32'hCAFEF00D, 4'h1, LF},          // R3 align
    {4'd10, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h8, 32'h0F0E0D0C, 4'h8, 32'h0F0E0D0C}, // R10
    {4'd4,  1'b0, 1'b1, 4'hF, 4'hF, 4'h0, 4'h0, 32'h55AA55AA, 4'h0, 32'h55AA55AA}, // R4
    {4'd5,  1'b0, 1'b0, 4'h0, 4'h0, 4'h4, 4'h0, 32'h11223344, 4'h4, 32'h11FE3344}, // R5
    {4'd5,  1'b0, 1'b0, 4'h0, 4'h0, 4'h9, 4'h2, 32'h00BC0000, 4'hB, 32'hFEBC00FE}, // R5
    {4'd6,  1'b1, 1'b1, 4'h0, 4'h0, 4'hF, 4'h0, 32'h99887766, 4'h1, LF},          // R6
    {4'd7,  1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h1, LF,           4'h1, LF},          // R7 local
    {4'd7,  1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h1, 32'h0200009C, 4'h1, 32'h0200009C}, // R7 remote
    {4'd6,  1'b0, 1'b0, 4'h0, 4'h1, 4'h2, 4'h0, 32'h77665544, 4'h2, 32'h7766FE44}  // R6 prop off
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [89:0] v);
    prop_en    = v[85];
    align_lost = v[84];
    bsync_lost = v[83:80];
    los        = v[79:76];
    in_viol    = v[75:72];
    in_ctl     = v[71:68];
    in_data    = v[67:36];
    in_valid   = 1'b1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {out_ctl, out_data}, 36'h0);
    check("R9", {35'h0, out_valid}, 36'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][89:86]), {out_ctl, out_data}, VEC[i][35:0]);
      check("R1", {35'h0, out_valid}, 36'h1);
    end

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive({4'd8, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h3, 32'hDEADBEEF, 4'h0, 32'h0});
    @(posedge clk);
    #1 drive({4'd8, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h01020304, 4'h0, 32'h0});
    @(negedge clk);
    check("R8", {out_ctl, out_data}, {4'h3, 32'hDEADBEEF});
    check("R8", {35'h0, in_ready}, 36'h0);
    @(negedge clk);
    check("R8", {out_ctl, out_data}, {4'h3, 32'hDEADBEEF});
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R8", {out_ctl, out_data}, {4'h0, 32'h01020304});
    @(negedge clk);
    check("R1", {35'h0, out_valid}, 36'h0);

    // R10 fault then immediate clear on consecutive columns
    drive({4'd10, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0A0B0C0D, 4'h0, 32'h0});
    @(negedge clk);
    check("R10", {out_ctl, out_data}, {4'h1, LF});
    drive({4'd10, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0A0B0C0D, 4'h0, 32'h0});
    @(negedge clk);
    check("R10", {out_ctl, out_data}, {4'h0, 32'h0A0B0C0D});
    in_valid = 1'b0;

    // R9 reset again clears output
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", {out_ctl, out_data}, 36'h0);
    check("R9", {35'h0, out_valid}, 36'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule